// File: doc/BRIEF.md
# Power-Fail Backup Store/Recall Sequencer

This block manages a byte-wide working RAM that has a hidden nonvolatile shadow of the same depth. The host sees only the working RAM, through a plain synchronous read/write port. The block watches a supply-good flag from an external comparator. When that flag drops, it shuts out the host at once and raises a reserve-power flag. If the working RAM has been written since the last full copy, and automatic saving is not disabled, it then copies every word into the shadow. When the supply comes back, it copies the whole shadow into the working RAM before it lets the host back in.

Software can request the same full-array store or recall at any time while the block is idle. Each word of a store is followed by a programmable settle time that stands in for the nonvolatile write latency. A one-cycle done pulse marks the end of every completed copy. Depth is set by `ADDR_W`: 16 gives 65,536 words and 17 gives 131,072. The default is small so that a quick build stays light.

Top module: `pfb_backup_seq`

## Requirements
- R1: While reset is applied, and right after it, `busy` is 1, `xfer_done` is 0 and `array_dirty` is 0. When reset ends with `supply_ok` high, a power-up recall runs, and `busy` falls when it finishes.
- R2: While idle, a write strobe stores `host_wdata` at `host_addr`. A read strobe returns the addressed byte on `host_rdata`, with `host_rvalid` high, in the cycle after the strobe.
- R3: Any accepted host write sets `array_dirty` by the next cycle. Every completed store or recall clears it in the same cycle as its done pulse.
- R4: A software store strobe copies every working word to the shadow. `busy` stays high for exactly 2^ADDR_W × (2 + NV_WAIT) cycles. `xfer_done` is then high for one cycle, in the first cycle in which `busy` is low again.
- R5: A software recall strobe copies every shadow word back into the working array, overwriting host changes. `busy` stays high for exactly 2^ADDR_W × 2 cycles.
- R6: A clock edge that samples `supply_ok` low leaves `on_reserve` and `busy` high. A host write presented in that same cycle is dropped.
- R7: A supply drop while idle, with `array_dirty`=1 and `autostore_off`=0, runs a full store: one done pulse, then the off state. Data written before the drop survives the power cycle.
- R8: A supply drop with `autostore_off`=1, or with `array_dirty`=0, skips the store: there is no done pulse. Writes made since the last copy are lost over the power cycle.
- R9: When the supply returns, the shadow is recalled in full and then `busy` falls. `on_reserve` is low once `supply_ok` has been sampled high in the off state.
- R10: While `supply_ok` stays low, the block stays off. `busy` stays high and store or recall strobes have no effect.
- R11: A supply drop during a software recall aborts the recall. The block then starts an automatic store, under the same conditions as R7, from word 0. Words the recall had not yet reached are saved with their host-written values.
- R12: A supply drop during a software store does not stop it. The store completes with its done pulse, and the block then goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Comparator output; 1 means supply above trip level |
| autostore_off | input | 1 | 1 disables the automatic store on supply loss |
| sw_store | input | 1 | Software store request strobe |
| sw_recall | input | 1 | Software recall request strobe |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| busy | output | 1 | 1 while any copy runs or the block is off |
| on_reserve | output | 1 | 1 while running from reserve power |
| xfer_done | output | 1 | One-cycle pulse when a full copy completes |
| array_dirty | output | 1 | Working array modified since the last copy |

## Verification
If the sequencer state is corrupted, `busy` stays stuck, or it falls at the wrong time. A busy window counted at the ports catches this within one full copy, which takes 2^ADDR_W × (2 + NV_WAIT) cycles at most. A wrong address counter or direction select shows only as wrong data: it appears on the first host read after a recall or a power cycle. A misbehaving modified flag shows as a done pulse that is missing or extra after a supply drop, within one store time of the drop.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_PU_RECALL,
        ST_READY,
        ST_SW_STORE,
        ST_SW_RECALL,
        ST_AUTO_STORE
    } pfb_state_e;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_PUT,
        PH_SETTLE
    } pfb_phase_e;
endpackage

// File: rtl/pfb_ram.sv
module pfb_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/pfb_walk.sv
module pfb_walk
    import pfb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int NV_WAIT = 2,
    parameter int WCW     = 1
) (
    input  pfb_phase_e     phase_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [WCW-1:0] wcnt_i,
    input  logic           store_i,
    output pfb_phase_e     phase_o,
    output logic [AW-1:0]  addr_o,
    output logic [WCW-1:0] wcnt_o,
    output logic           finish_o
);
    localparam logic [AW-1:0]  LAST_ADDR = {AW{1'b1}};
    localparam bit             HAS_WAIT  = (NV_WAIT > 0);
    localparam logic [WCW-1:0] WAIT_LOAD = WCW'(HAS_WAIT ? NV_WAIT - 1 : 0);

    logic advance;

    always_comb begin
        phase_o  = phase_i;
        addr_o   = addr_i;
        wcnt_o   = wcnt_i;
        advance  = 1'b0;
        finish_o = 1'b0;
        case (phase_i)
            PH_FETCH: phase_o = PH_PUT;
            PH_PUT: begin
                if (store_i && HAS_WAIT) begin
                    phase_o = PH_SETTLE;
                    wcnt_o  = WAIT_LOAD;
                end else begin
                    advance = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (wcnt_i == '0) advance = 1'b1;
                else              wcnt_o  = wcnt_i - WCW'(1);
            end
            default: phase_o = PH_FETCH;
        endcase
        if (advance) begin
            phase_o = PH_FETCH;
            if (addr_i == LAST_ADDR) begin
                finish_o = 1'b1;
                addr_o   = '0;
            end else begin
                addr_o = addr_i + AW'(1);
            end
        end
    end
endmodule

// File: rtl/pfb_backup_seq.sv
module pfb_backup_seq
    import pfb_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int NV_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              autostore_off,
    input  logic              sw_store,
    input  logic              sw_recall,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy,
    output logic              on_reserve,
    output logic              xfer_done,
    output logic              array_dirty
);
    localparam int WCW = (NV_WAIT > 1) ? $clog2(NV_WAIT) : 1;

    typedef struct packed {
        pfb_state_e       state;
        pfb_phase_e       phase;
        logic [ADDR_W-1:0] addr;
        logic [WCW-1:0]   wcnt;
        logic             dirty;
        logic             done;
        logic             rvalid;
        logic             on_res;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              work_we, sh_we;
    logic [ADDR_W-1:0] work_addr;
    logic [DATA_W-1:0] work_wdata, work_rdata, sh_rdata;
    pfb_phase_e        w_phase;
    logic [ADDR_W-1:0] w_addr;
    logic [WCW-1:0]    w_wcnt;
    logic              w_finish;
    logic              store_run, recall_run, start_auto;
    pfb_state_e        cur_state;

    assign cur_state  = q.state;
    assign store_run  = (q.state == ST_SW_STORE) || (q.state == ST_AUTO_STORE);
    assign recall_run = (q.state == ST_PU_RECALL) || (q.state == ST_SW_RECALL);
    assign start_auto = q.dirty && !autostore_off;

    pfb_walk #(.AW(ADDR_W), .NV_WAIT(NV_WAIT), .WCW(WCW)) u_walk (
        .phase_i (q.phase),
        .addr_i  (q.addr),
        .wcnt_i  (q.wcnt),
        .store_i (store_run),
        .phase_o (w_phase),
        .addr_o  (w_addr),
        .wcnt_o  (w_wcnt),
        .finish_o(w_finish)
    );

    pfb_ram #(.AW(ADDR_W), .DW(DATA_W)) u_work (
        .clk  (clk),
        .we   (work_we),
        .addr (work_addr),
        .wdata(work_wdata),
        .rdata(work_rdata)
    );

    pfb_ram #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
        .clk  (clk),
        .we   (sh_we),
        .addr (q.addr),
        .wdata(work_rdata),
        .rdata(sh_rdata)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.rvalid   = 1'b0;
        work_we    = 1'b0;
        work_addr  = host_addr;
        work_wdata = host_wdata;
        sh_we      = 1'b0;

        if (store_run) begin
            work_addr = q.addr;
            sh_we     = (q.phase == PH_PUT);
        end
        if (recall_run) begin
            work_addr  = q.addr;
            work_wdata = sh_rdata;
            work_we    = (q.phase == PH_PUT);
        end
        if (!supply_ok) d.on_res = 1'b1;

        case (q.state)
            ST_OFF: begin
                if (supply_ok) begin
                    d.state  = ST_PU_RECALL;
                    d.on_res = 1'b0;
                    d.addr   = '0;
                    d.phase  = PH_FETCH;
                end
            end
            ST_READY: begin
                d.addr  = '0;
                d.phase = PH_FETCH;
                if (!supply_ok) begin
                    d.state = start_auto ? ST_AUTO_STORE : ST_OFF;
                end else if (sw_store) begin
                    d.state = ST_SW_STORE;
                end else if (sw_recall) begin
                    d.state = ST_SW_RECALL;
                end else if (host_wr) begin
                    work_we = 1'b1;
                    d.dirty = 1'b1;
                end else if (host_rd) begin
                    d.rvalid = 1'b1;
                end
            end
            ST_PU_RECALL, ST_SW_RECALL: begin
                if (!supply_ok) begin
                    d.addr  = '0;
                    d.phase = PH_FETCH;
                    d.state = (q.state == ST_SW_RECALL && start_auto)
                              ? ST_AUTO_STORE : ST_OFF;
                end else begin
                    d.addr  = w_addr;
                    d.phase = w_phase;
                    d.wcnt  = w_wcnt;
                    if (w_finish) begin
                        d.state = ST_READY;
                        d.dirty = 1'b0;
                        d.done  = 1'b1;
                    end
                end
            end
            ST_SW_STORE, ST_AUTO_STORE: begin
                d.addr  = w_addr;
                d.phase = w_phase;
                d.wcnt  = w_wcnt;
                if (w_finish) begin
                    d.dirty = 1'b0;
                    d.done  = 1'b1;
                    d.state = (supply_ok && q.state == ST_SW_STORE)
                              ? ST_READY : ST_OFF;
                end
            end
            default: d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_OFF;
            q.phase  <= PH_FETCH;
            q.addr   <= '0;
            q.wcnt   <= '0;
            q.dirty  <= 1'b0;
            q.done   <= 1'b0;
            q.rvalid <= 1'b0;
            q.on_res <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign host_rdata  = work_rdata;
    assign host_rvalid = q.rvalid;
    assign busy        = (q.state != ST_READY);
    assign on_reserve  = q.on_res;
    assign xfer_done   = q.done;
    assign array_dirty = q.dirty;
endmodule

// File: rtl/pfb_backup_seq_chk.sv
module pfb_backup_seq_chk
    import pfb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       busy,
    input logic       on_reserve,
    input logic       done,
    input logic       dirty,
    input logic       rvalid,
    input logic       work_we,
    input logic       sh_we,
    input pfb_state_e state
);
    assert_reserve_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> on_reserve);

    assert_shadow_write_in_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_we |-> (state == ST_SW_STORE || state == ST_AUTO_STORE));

    assert_work_write_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        work_we |-> (state == ST_READY || state == ST_PU_RECALL || state == ST_SW_RECALL));

    assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_clears_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dirty);

    assert_off_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !supply_ok) |=> state == ST_OFF);

    assert_rvalid_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !$past(busy));

    assert_store_runs_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SW_STORE |=> (state == ST_SW_STORE || done));
endmodule

bind pfb_backup_seq pfb_backup_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .busy      (busy),
    .on_reserve(on_reserve),
    .done      (xfer_done),
    .dirty     (array_dirty),
    .rvalid    (host_rvalid),
    .work_we   (work_we),
    .sh_we     (sh_we),
    .state     (cur_state)
);

// File: tb/tb_pfb_backup_seq.sv
module tb_pfb_backup_seq;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int NVW   = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          autostore_off = 1'b0;
    logic          sw_store = 1'b0;
    logic          sw_recall = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid, busy, on_reserve, xfer_done, array_dirty;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pfb_backup_seq #(.ADDR_W(AW), .DATA_W(DW), .NV_WAIT(NVW)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .autostore_off(autostore_off),
        .sw_store(sw_store), .sw_recall(sw_recall), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .busy(busy), .on_reserve(on_reserve),
        .xfer_done(xfer_done), .array_dirty(array_dirty)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (xfer_done) done_cnt <= done_cnt + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        check(req, int'(host_rvalid), 1);
        check(req, int'(host_rdata), int'(exp));
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // entry: {is_write, addr[3:0], data[7:0]}
    localparam logic [12:0] VEC [14] = '{
        {1'b1, 4'd0, 8'h0F}, {1'b1, 4'd1, 8'h1E}, {1'b1, 4'd2, 8'h2D},
        {1'b1, 4'd3, 8'h3C}, {1'b1, 4'd4, 8'h4B}, {1'b1, 4'd5, 8'h5A},
        {1'b1, 4'd6, 8'h69}, {1'b1, 4'd7, 8'h78}, {1'b1, 4'd8, 8'h87},
        {1'b0, 4'd0, 8'h0F}, {1'b0, 4'd3, 8'h3C}, {1'b0, 4'd8, 8'h87},
        {1'b1, 4'd3, 8'hC3}, {1'b0, 4'd3, 8'hC3}
    };

    initial begin
        int n;
        int d0;
        // R1: reset state
        run_cycles(3);
        check("R1 busy in reset", int'(busy), 1);
        check("R1 done in reset", int'(xfer_done), 0);
        check("R1 dirty in reset", int'(array_dirty), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 1);
        wait_ready();
        check("R1 idle after power-up recall", int'(busy), 0);
        check("R3 clean after recall", int'(array_dirty), 0);

        // R2: table walk
        foreach (VEC[i]) begin
            if (VEC[i][12]) do_wr(VEC[i][11:8], VEC[i][7:0]);
            else            do_rd("R2 table read", VEC[i][11:8], VEC[i][7:0]);
        end
        check("R3 dirty after writes", int'(array_dirty), 1);
        do_wr(4'd3, 8'h3C);

        // R4: software store timing
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R4 store busy cycles", n, DEPTH * (2 + NVW));
        check("R4 done pulse", int'(xfer_done), 1);
        check("R3 clean after store", int'(array_dirty), 0);

        // R5: software recall restores stored image
        do_wr(4'd3, 8'hEE);
        do_rd("R5 pre-recall", 4'd3, 8'hEE);
        @(negedge clk); sw_recall = 1'b1;
        @(negedge clk); sw_recall = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R5 recall busy cycles", n, DEPTH * 2);
        do_rd("R5 restored", 4'd3, 8'h3C);

        // R6/R7/R10/R9: drop while dirty
        do_wr(4'd5, 8'hB5);
        d0 = done_cnt;
        @(negedge clk);
        supply_ok = 1'b0; host_wr = 1'b1; host_addr = 4'd6; host_wdata = 8'h66;
        @(negedge clk);
        host_wr = 1'b0;
        check("R6 on_reserve", int'(on_reserve), 1);
        check("R6 busy", int'(busy), 1);
        run_cycles(DEPTH * (2 + NVW) + 10);
        check("R7 auto store done", done_cnt - d0, 1);
        d0 = done_cnt;
        @(negedge clk); sw_recall = 1'b1; sw_store = 1'b1;
        @(negedge clk); sw_recall = 1'b0; sw_store = 1'b0;
        run_cycles(40);
        check("R10 still busy", int'(busy), 1);
        check("R10 no transfer", done_cnt - d0, 0);
        supply_ok = 1'b1;
        run_cycles(2);
        check("R9 reserve released", int'(on_reserve), 0);
        check("R9 busy during recall", int'(busy), 1);
        wait_ready();
        do_rd("R7 data kept", 4'd5, 8'hB5);
        do_rd("R6 write dropped", 4'd6, 8'h69);

        // R8: automatic store disabled
        autostore_off = 1'b1;
        do_wr(4'd5, 8'h11);
        d0 = done_cnt;
        @(negedge clk); supply_ok = 1'b0;
        run_cycles(DEPTH * (2 + NVW) + 10);
        check("R8 no store when disabled", done_cnt - d0, 0);
        supply_ok = 1'b1; autostore_off = 1'b0;
        @(negedge clk); wait_ready();
        do_rd("R8 unstored write lost", 4'd5, 8'hB5);

        // R8: not modified
        d0 = done_cnt;
        @(negedge clk); supply_ok = 1'b0;
        run_cycles(DEPTH * (2 + NVW) + 10);
        check("R8 no store when clean", done_cnt - d0, 0);
        supply_ok = 1'b1;
        @(negedge clk); wait_ready();

        // R12: drop during software store
        do_wr(4'd7, 8'h77);
        d0 = done_cnt;
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
        run_cycles(10);
        supply_ok = 1'b0;
        run_cycles(DEPTH * (2 + NVW) + 10);
        check("R12 store completed", done_cnt - d0, 1);
        check("R12 off after store", int'(busy), 1);
        supply_ok = 1'b1;
        @(negedge clk); wait_ready();
        do_rd("R12 data saved", 4'd7, 8'h77);

        // R11: drop during software recall
        do_wr(4'd8, 8'h88);
        d0 = done_cnt;
        @(negedge clk); sw_recall = 1'b1;
        @(negedge clk); sw_recall = 1'b0;
        run_cycles(4);
        supply_ok = 1'b0;
        run_cycles(DEPTH * (2 + NVW) + 10);
        check("R11 one store, recall aborted", done_cnt - d0, 1);
        supply_ok = 1'b1;
        @(negedge clk); wait_ready();
        do_rd("R11 unreached word saved", 4'd8, 8'h88);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule